// File: doc/BRIEF.md
# Rotating Register Renaming File

This block is a small register file for a loop accelerator. It is split into a static region and a rotating region, and it carries a short group of stage predicates. Logical register numbers below the rotating window reach the same physical entry every time. Numbers inside the window are renamed through a modular base offset. Each rotate strobe decrements that base, so a value written under one logical name is found under the next higher name one loop iteration later. No data has to be copied.

Together with the base, the stage predicates shift by one place on every rotate, and a fresh bit enters the first stage. A software-pipelined loop body can therefore enable each stage from its own predicate bit. The loop-closing branch logic that raises the rotate strobe sits outside this block.

There are two combinational read ports and one write port, all addressed by logical index. Each write is qualified by a predicate bit, and a write with a clear qualifier leaves the file untouched.

Top module: `rot_rename_file`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the rotating base to 0 and every stage predicate to 0. After reset, logical index 32+i reaches the same physical entry as it did before any rotation. Register contents are kept.
- R2: Logical indices 0 to 31 are never renamed. A value written to one of them reads back under the same index after any number of rotations.
- R3: After k rotations, a value written to logical 32+i at base 0 reads at logical 32+((i+k) mod 8). After eight rotations the mapping is back where it started.
- R4: A write commits only when wr_en and wr_qual are both 1. Otherwise the addressed register keeps its old value.
- R5: On a rotate, stage_pred[0] takes rot_stage_bit, stage_pred[1] takes the old stage_pred[0], and stage_pred[2] takes the old stage_pred[1]. Without a rotate the predicates hold their values.
- R6: A write and a rotate in the same cycle use the pre-rotation mapping for the write. Data written to logical 32 in that cycle reads at logical 33 from the next cycle on.
- R7: Both read ports are combinational and independent. They show the current mapping in the same cycle, and a write becomes visible after the rising edge that commits it.
- R8: Logical indices 40 and above are out of range. Reads from them return 0, and writes to them change no register.
- R9: A three-stage loop runs over five elements: load to logical 32, add one from 33 into 34, then store from 35. Each stage is gated by its stage predicate, and the loop stores exactly the five inputs plus one, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 6 | Logical index for read port A |
| rd_a_data | output | 16 | Read data for port A (combinational) |
| rd_b_idx | input | 6 | Logical index for read port B |
| rd_b_data | output | 16 | Read data for port B (combinational) |
| wr_en | input | 1 | Write request |
| wr_qual | input | 1 | Predicate qualifier for the write |
| wr_idx | input | 6 | Logical index to write |
| wr_data | input | 16 | Write data |
| rot_i | input | 1 | Rotate strobe: decrement the base and shift the predicates |
| rot_stage_bit | input | 1 | New value for the first stage predicate on a rotate |
| stage_pred | output | 3 | Current stage predicates, bit 0 is the first stage |

## Verification
The assertions assume that rst is high at the first rising edge and that all inputs hold known values from time zero. They also assume the indices change only between clock edges. The bench meets this by driving every input at time zero, holding reset for two edges, and changing stimulus only on falling edges or just after rising edges. The rename-window checks further assume that any index below 64 may appear, and the bench uses out-of-range indices on purpose to exercise the zero-read path.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  // Maps a logical register number to a physical entry.
  // Indices inside [rot_lo, rot_lo + 2**rot_log2) are offset by base
  // modulo the window size; all others pass through unchanged.
  function automatic int unsigned rrf_rename(input int unsigned lidx,
                                             input int unsigned base,
                                             input int unsigned rot_lo,
                                             input int unsigned rot_log2);
    int unsigned win;
    win = 32'd1 << rot_log2;
    if (lidx >= rot_lo && lidx < rot_lo + win)
      return rot_lo + ((lidx - rot_lo + base) & (win - 1));
    return lidx;
  endfunction

endpackage

// File: rtl/rrf_index_map.sv
module rrf_index_map #(
  parameter int IDX_W    = 6,
  parameter int NUM_LOG  = 40,
  parameter int ROT_LO   = 32,
  parameter int ROT_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    lidx,
  input  logic [ROT_LOG2-1:0] base,
  output logic [IDX_W-1:0]    pidx,
  output logic                valid
);
  import rrf_pkg::*;

  localparam int ROT_N = 1 << ROT_LOG2;

  logic in_window;
  logic in_static;

  assign valid     = 32'(lidx) < NUM_LOG;
  assign in_window = valid && (32'(lidx) >= ROT_LO);
  assign in_static = 32'(lidx) < ROT_LO;
  assign pidx      = IDX_W'(rrf_rename(32'(lidx), 32'(base), ROT_LO, ROT_LOG2));

  AST_MAP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    in_window |-> (32'(pidx) >= ROT_LO && 32'(pidx) < ROT_LO + ROT_N)); // R3

  AST_STATIC_UNRENAMED: assert property (@(posedge clk) disable iff (rst)
    in_static |-> (pidx == lidx)); // R2

endmodule

// File: rtl/rrf_rot_ctl.sv
module rrf_rot_ctl #(
  parameter int ROT_LOG2 = 3,
  parameter int NSTAGE   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rot_i,
  input  logic                stage_bit_i,
  output logic [ROT_LOG2-1:0] base_o,
  output logic [NSTAGE-1:0]   pred_o
);
  logic [ROT_LOG2-1:0] base_q;
  logic [NSTAGE-1:0]   pred_q;
  logic                rot_evt;

  assign rot_evt = rot_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      pred_q <= '0;
    end else if (rot_evt) begin
      base_q <= base_q - 1'b1;
      pred_q <= {pred_q[NSTAGE-2:0], stage_bit_i};
    end
  end

  assign base_o = base_q;
  assign pred_o = pred_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (base_q == '0 && pred_q == '0)); // R1

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    rot_evt |=> (base_q == $past(base_q) - 1'b1)); // R3

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rot_evt |=> $stable(base_q)); // R3

  AST_PRED_SHIFT: assert property (@(posedge clk) disable iff (rst)
    rot_evt |=> (pred_q[NSTAGE-1:1] == $past(pred_q[NSTAGE-2:0]) &&
                 pred_q[0] == $past(stage_bit_i))); // R5

  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rot_evt |=> $stable(pred_q)); // R5

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int NPHYS  = 40,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [NPHYS-1:0][DATA_W-1:0] mem;
  logic [NPHYS-1:0]             entry_we;

  for (genvar e = 0; e < NPHYS; e++) begin : g_entry
    assign entry_we[e] = we && (32'(widx) == e);
    always_ff @(posedge clk) begin
      if (entry_we[e]) mem[e] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    if (32'(raddr_a) < NPHYS) rdata_a = mem[raddr_a];
    if (32'(raddr_b) < NPHYS) rdata_b = mem[raddr_b];
  end

  AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mem)); // R4

  AST_SINGLE_ENTRY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(entry_we)); // R8

endmodule

// File: rtl/rot_rename_file.sv
module rot_rename_file #(
  parameter int DATA_W   = 16,
  parameter int NUM_LOG  = 40,
  parameter int ROT_LO   = 32,
  parameter int ROT_LOG2 = 3,
  parameter int NSTAGE   = 3,
  localparam int IDX_W   = $clog2(NUM_LOG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic              wr_qual,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rot_i,
  input  logic              rot_stage_bit,
  output logic [NSTAGE-1:0] stage_pred
);
  localparam int NPORT = 3; // 0: read A, 1: read B, 2: write

  logic [ROT_LOG2-1:0]          base;
  logic [NPORT-1:0][IDX_W-1:0]  lidx_all;
  logic [NPORT-1:0][IDX_W-1:0]  pidx_all;
  logic [NPORT-1:0]             valid_all;
  logic                         wr_commit;
  logic [DATA_W-1:0]            raw_a;
  logic [DATA_W-1:0]            raw_b;

  assign lidx_all = {wr_idx, rd_b_idx, rd_a_idx};

  rrf_rot_ctl #(.ROT_LOG2(ROT_LOG2), .NSTAGE(NSTAGE)) u_ctl (
    .clk(clk), .rst(rst), .rot_i(rot_i), .stage_bit_i(rot_stage_bit),
    .base_o(base), .pred_o(stage_pred)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rrf_index_map #(.IDX_W(IDX_W), .NUM_LOG(NUM_LOG), .ROT_LO(ROT_LO),
                    .ROT_LOG2(ROT_LOG2)) u_map (
      .clk(clk), .rst(rst), .lidx(lidx_all[p]), .base(base),
      .pidx(pidx_all[p]), .valid(valid_all[p])
    );
  end

  // Write uses the mapping of the current cycle, before any rotate lands.
  assign wr_commit = wr_en && wr_qual && valid_all[2];

  rrf_storage #(.NPHYS(NUM_LOG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst(rst), .we(wr_commit), .widx(pidx_all[2]), .wdata(wr_data),
    .raddr_a(pidx_all[0]), .raddr_b(pidx_all[1]),
    .rdata_a(raw_a), .rdata_b(raw_b)
  );

  assign rd_a_data = valid_all[0] ? raw_a : '0;
  assign rd_b_data = valid_all[1] ? raw_b : '0;

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_a_idx) >= NUM_LOG) |-> (rd_a_data == '0)); // R8

  AST_UNQUALIFIED_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !wr_qual |-> !wr_commit); // R4

endmodule

// File: tb/test_rot_rename_file.sv
module test_rot_rename_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, wr_qual = 1'b0, rot_i = 1'b0, rot_stage_bit = 1'b0;
  logic [2:0]  stage_pred;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  rot_rename_file i_rot_rename_file (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_qual(wr_qual), .wr_idx(wr_idx), .wr_data(wr_data), .rot_i(rot_i),
    .rot_stage_bit(rot_stage_bit), .stage_pred(stage_pred)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic cyc(input logic [5:0] idx, input logic [15:0] d, input logic en,
                     input logic q, input logic r, input logic b);
    @(negedge clk);
    wr_idx = idx; wr_data = d; wr_en = en; wr_qual = q; rot_i = r; rot_stage_bit = b;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_qual = 1'b0; rot_i = 1'b0; rot_stage_bit = 1'b0;
  endtask

  task automatic wr(input logic [5:0] idx, input logic [15:0] d);
    cyc(idx, d, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic rotate(input logic b);
    cyc(6'd0, 16'h0, 1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic rd(input logic [5:0] a, input logic [5:0] b,
                    output logic [15:0] da, output logic [15:0] db);
    @(negedge clk);
    rd_a_idx = a; rd_b_idx = b;
    #1;
    da = rd_a_data; db = rd_b_data;
  endtask

  task automatic t_reset();
    logic [15:0] da, db;
    do_reset();
    chk("R1 predicates after reset", 32'(stage_pred), 32'h0);
    for (int i = 0; i < 8; i++) wr(6'(32 + i), 16'(16'h200 + i));
    rotate(1'b1); rotate(1'b1); rotate(1'b1);
    chk("R5 predicates set before reset", 32'(stage_pred), 32'h7);
    do_reset();
    chk("R1 predicates cleared", 32'(stage_pred), 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(6'(32 + i), 6'd0, da, db);
      chk("R1 base back to zero", 32'(da), 32'(16'h200 + i));
    end
  endtask

  task automatic t_static();
    logic [15:0] da, db;
    do_reset();
    wr(6'd5, 16'h1234);
    wr(6'd31, 16'h4321);
    repeat (3) rotate(1'b0);
    rd(6'd5, 6'd31, da, db);
    chk("R2 r5 not renamed", 32'(da), 32'h1234);
    chk("R2 r31 not renamed", 32'(db), 32'h4321);
  endtask

  task automatic t_rotate();
    logic [15:0] da, db;
    do_reset();
    for (int i = 0; i < 8; i++) wr(6'(32 + i), 16'(16'h100 + i));
    for (int k = 1; k <= 8; k++) begin
      rotate(1'b0);
      for (int i = 0; i < 8; i += 3) begin
        rd(6'(32 + ((i + k) % 8)), 6'd0, da, db);
        chk("R3 renamed read", 32'(da), 32'(16'h100 + i));
      end
    end
    rd(6'd32, 6'd39, da, db);
    chk("R3 wrap r32", 32'(da), 32'h100);
    chk("R3 wrap r39", 32'(db), 32'h107);
  endtask

  task automatic t_qual();
    logic [15:0] da, db;
    do_reset();
    wr(6'd34, 16'hAAAA);
    cyc(6'd34, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(6'd34, 6'd0, da, db);
    chk("R4 unqualified write suppressed", 32'(da), 32'hAAAA);
    cyc(6'd34, 16'h6666, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(6'd34, 6'd0, da, db);
    chk("R4 no write without enable", 32'(da), 32'hAAAA);
    wr(6'd10, 16'h0B0B);
    cyc(6'd10, 16'h0C0C, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(6'd10, 6'd0, da, db);
    chk("R4 static unqualified suppressed", 32'(da), 32'h0B0B);
  endtask

  task automatic t_pred();
    do_reset();
    rotate(1'b1);
    chk("R5 after first rotate", 32'(stage_pred), 32'h1);
    rotate(1'b0);
    chk("R5 after second rotate", 32'(stage_pred), 32'h2);
    rotate(1'b1);
    chk("R5 after third rotate", 32'(stage_pred), 32'h5);
    cyc(6'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 hold without rotate", 32'(stage_pred), 32'h5);
    rotate(1'b0);
    chk("R5 oldest drops out", 32'(stage_pred), 32'h2);
  endtask

  task automatic t_same_cycle();
    logic [15:0] da, db;
    do_reset();
    cyc(6'd32, 16'hBEEF, 1'b1, 1'b1, 1'b1, 1'b0);
    rd(6'd33, 6'd0, da, db);
    chk("R6 write with rotate uses old mapping", 32'(da), 32'hBEEF);
  endtask

  task automatic t_dual_read();
    logic [15:0] da, db;
    do_reset();
    wr(6'd3, 16'h0033);
    wr(6'd36, 16'h3636);
    rd(6'd3, 6'd36, da, db);
    chk("R7 port A", 32'(da), 32'h0033);
    chk("R7 port B", 32'(db), 32'h3636);
    @(negedge clk);
    rd_a_idx = 6'd3; wr_idx = 6'd3; wr_data = 16'h7777; wr_en = 1'b1; wr_qual = 1'b1;
    #1;
    chk("R7 write not visible before edge", 32'(rd_a_data), 32'h0033);
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_qual = 1'b0;
    chk("R7 write visible after edge", 32'(rd_a_data), 32'h7777);
  endtask

  task automatic t_range();
    logic [15:0] da, db;
    do_reset();
    wr(6'd5, 16'h5005);
    wr(6'd13, 16'h1313);
    wr(6'd37, 16'h3737);
    wr(6'd45, 16'hDEAD);
    wr(6'd63, 16'hDEAD);
    rd(6'd45, 6'd63, da, db);
    chk("R8 out-of-range read r45", 32'(da), 32'h0);
    chk("R8 out-of-range read r63", 32'(db), 32'h0);
    rd(6'd5, 6'd13, da, db);
    chk("R8 r5 untouched", 32'(da), 32'h5005);
    chk("R8 r13 untouched", 32'(db), 32'h1313);
    rd(6'd37, 6'd0, da, db);
    chk("R8 r37 untouched", 32'(da), 32'h3737);
  endtask

  task automatic t_loop();
    logic [15:0] xs [5];
    logic [15:0] ys [5];
    logic [15:0] sum;
    logic [2:0]  p;
    int n_st;
    xs[0] = 16'd3; xs[1] = 16'd10; xs[2] = 16'h7FFE; xs[3] = 16'd200; xs[4] = 16'hFFFF;
    n_st = 0;
    do_reset();
    rotate(1'b1);
    for (int it = 0; it < 7; it++) begin
      p = stage_pred;
      // stage 1: load into logical 32
      cyc(6'd32, (it < 5) ? xs[it] : 16'h0, 1'b1, p[0], 1'b0, 1'b0);
      // stages 2 and 3: add from 33 into 34, store from 35
      @(negedge clk);
      rd_a_idx = 6'd33; rd_b_idx = 6'd35;
      #1;
      sum = rd_a_data + 16'd1;
      if (p[2]) begin
        if (n_st < 5) ys[n_st] = rd_b_data;
        n_st++;
      end
      wr_idx = 6'd34; wr_data = sum; wr_en = 1'b1; wr_qual = p[1];
      rot_i = 1'b1; rot_stage_bit = (it + 1 < 5);
      @(posedge clk);
      #1;
      wr_en = 1'b0; wr_qual = 1'b0; rot_i = 1'b0; rot_stage_bit = 1'b0;
    end
    chk("R9 store count", 32'(n_st), 32'd5);
    for (int k = 0; k < 5; k++)
      chk("R9 stored value", 32'(ys[k]), 32'(16'(xs[k] + 16'd1)));
    chk("R5 predicates drained after loop", 32'(stage_pred), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_static();
    t_rotate();
    t_qual();
    t_pred();
    t_same_cycle();
    t_dual_read();
    t_range();
    t_loop();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule